// File: doc/BRIEF.md
# Microcontroller Watchdog Timer

This block guards a microcontroller against runaway software. It holds an 8-bit control word. The top bit is an arm flag, and the lower seven bits are a down-counter. A free-running prescaler decrements the counter at a fixed rate. Software must reload the counter before bit 6 drops to zero. If it does not, and the watchdog is armed, the block drives an active-low system reset pulse of fixed length.

The counter runs whether or not the block is armed. Software can set the arm flag but cannot clear it; only a reset clears it. A configuration input can arm the block from reset onwards. While armed, a halt request from the core also triggers the reset pulse. Software can also force an immediate reset by writing a word that sets the arm flag and leaves bit 6 clear. During the pulse, the control word is reinitialised.

Top module: `wdog_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data` is 7Fh with bit 7 equal to `hw_en`, and `sys_rst_n` is high.
- R2: Bits 6..0 of `rd_data` decrement by one on every TICK_DIV-th clock edge after reset, where TICK_DIV = 2^(PRE_LO_W+PRE_HI_W). This holds whether or not the block is armed, and the count wraps from 00h to 7Fh.
- R3: A write with `wr_en` loads `wr_data[6:0]` into the counter and ORs `wr_data[7]` into the arm flag (bit 7). Writing 0 to bit 7 never disarms the block.
- R4: A write that lands on a tick edge takes the written value with no decrement. A write never restarts the prescaler, so the next decrement still follows the free-running tick grid.
- R5: When the block is armed and the counter steps from 40h to 3Fh, `sys_rst_n` goes low on the next clock edge.
- R6: A write with bit 7 set and bit 6 clear starts the reset pulse on the edge after the write.
- R7: If `halt_req` is high in a cycle where the block is armed and no pulse is running, the pulse starts at the end of that cycle. When the block is not armed, `halt_req` has no effect.
- R8: `sys_rst_n` stays low for exactly PULSE_CYC cycles. Halt requests, counter expiry and writes during the pulse neither extend it nor start a second one.
- R9: While `sys_rst_n` is low, and right after its release, `rd_data` is 7Fh with bit 7 equal to `hw_en`.
- R10: With `hw_en` high, the block is armed from reset and after every pulse, and it stays armed.
- R11: A halt request in the same cycle as a counter expiry gives one pulse of PULSE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Arms the watchdog unconditionally at reset and after each pulse |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 8 | Write data: bit 7 arms, bits 6..0 load the counter |
| halt_req | input | 1 | Halt request strobe from the core |
| rd_data | output | 8 | Current control word: arm flag and counter |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a software write and a prescaler tick. The bench waits until the edge counter sits one cycle before a tick boundary and then writes, so that the write lands on the tick edge. It judges the result by requiring the loaded value to hold for a full tick period. The second pair is a halt request and the 40h-to-3Fh expiry. The bench raises `halt_req` in exactly the cycle after the decrement edge, and requires a single pulse of the nominal length that is never extended.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W = 7;
  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  typedef struct packed {
    logic             armed;
    logic [CNT_W-1:0] cnt;
  } wdog_ctl_t;

  // Expiry: armed and the counter's top bit has cleared.
  function automatic logic ctl_expired(wdog_ctl_t c);
    return c.armed && !c.cnt[CNT_W-1];
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned LO_W = 12,
  parameter int unsigned HI_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [LO_W-1:0] lo_q;
  logic            lo_wrap;

  always_ff @(posedge clk) begin
    if (rst) lo_q <= '0;
    else     lo_q <= lo_q + 1'b1;
  end

  assign lo_wrap = &lo_q;

  generate
    if (HI_W == 0) begin : g_no_div
      assign tick = lo_wrap;
    end else begin : g_div
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)          hi_q <= '0;
        else if (lo_wrap) hi_q <= hi_q + 1'b1;
      end
      assign tick = lo_wrap & (&hi_q);
    end
  endgenerate
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_en,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  input  logic             tick,
  output wdog_ctl_t        ctl_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ctl_q <= '{armed: hw_en, cnt: CNT_INIT};
    end else if (wr_en) begin
      ctl_q <= '{armed: ctl_q.armed | wr_data[CNT_W], cnt: wr_data[CNT_W-1:0]};
    end else if (tick) begin
      ctl_q.cnt <= ctl_q.cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy,
  output logic pulse_n
);
  localparam int unsigned LW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [LW-1:0] LAST = LW'(PULSE_CYC - 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      left_q  <= '0;
      pulse_n <= 1'b1;
    end else if (fire) begin
      busy    <= 1'b1;
      left_q  <= LAST;
      pulse_n <= 1'b0;
    end else if (busy) begin
      if (left_q == '0) begin
        busy    <= 1'b0;
        pulse_n <= 1'b1;
      end else begin
        left_q  <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_LO_W  = 12,
  parameter int unsigned PRE_HI_W  = 2,
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hw_en,
  input  logic           wr_en,
  input  logic [CNT_W:0] wr_data,
  input  logic           halt_req,
  output logic [CNT_W:0] rd_data,
  output logic           sys_rst_n
);
  logic      tick;
  logic      busy;
  logic      fire;
  wdog_ctl_t ctl_q;

  wdog_prescale #(.LO_W(PRE_LO_W), .HI_W(PRE_HI_W)) i_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  assign fire = !busy && ctl_q.armed && (ctl_expired(ctl_q) || halt_req);

  wdog_regs i_regs (
    .clk    (clk),
    .rst    (rst),
    .hw_en  (hw_en),
    .clear  (fire | busy),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .tick   (tick),
    .ctl_q  (ctl_q)
  );

  wdog_pulse #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .busy   (busy),
    .pulse_n(sys_rst_n)
  );

  assign rd_data = ctl_q;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk #(
  parameter int unsigned PULSE_CYC = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       halt_req,
  input logic [7:0] rd_data,
  input logic       sys_rst_n
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 2);
  localparam logic [CW-1:0] NOM = CW'(PULSE_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (!sys_rst_n) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_n && !wr_en) |=> (!sys_rst_n || rd_data[6:0] == $past(rd_data[6:0])
                               || rd_data[6:0] == $past(rd_data[6:0]) - 7'd1));

  assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_data[7]) |-> !sys_rst_n);

  assert_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && !rd_data[6] && sys_rst_n) |=> !sys_rst_n);

  assert_halt_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && halt_req && sys_rst_n) |=> !sys_rst_n);

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> low_cnt == NOM);

  assert_reinit_R9: assert property (@(posedge clk) disable iff (rst)
    !sys_rst_n |-> rd_data[6:0] == 7'h7F);
endmodule

bind wdog_ctrl wdog_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .halt_req (halt_req),
  .rd_data  (rd_data),
  .sys_rst_n(sys_rst_n)
);

// File: tb/test_wdog_ctrl.sv
module test_wdog_ctrl;
  localparam int LO = 3;
  localparam int HI = 2;
  localparam int D  = 1 << (LO + HI);
  localparam int P  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       halt_req = 1'b0;
  logic [7:0] rd_data;
  logic       sys_rst_n;

  int edges = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  wdog_ctrl #(.PRE_LO_W(LO), .PRE_HI_W(HI), .PULSE_CYC(P)) i_wdog_ctrl (
    .clk(clk), .rst(rst), .hw_en(hw_en), .wr_en(wr_en), .wr_data(wr_data),
    .halt_req(halt_req), .rd_data(rd_data), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: got %0h expected %0h", req, edges, got, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [7:0] exp);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic chk_rn(input string req, input logic exp);
    check(sys_rst_n === exp, req, sys_rst_n, exp);
  endtask

  task automatic do_reset(input logic h);
    hw_en = h;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_rd("R1", {h, 7'h7F});
    chk_rn("R1", 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk_rd("R1", {h, 7'h7F});
    chk_rn("R1", 1'b1);
  endtask

  task automatic wr(input logic [7:0] v, output int w);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    w = edges;
  endtask

  task automatic wait_to(input int t);
    while (edges < t) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w, tk, h;
    @(negedge clk);
    do_reset(1'b0);

    // R2: disarmed free-running count, including 00h -> 7Fh wrap
    wr(8'h05, w);
    for (int e = w; e <= w + 9 * D; e++) begin
      int n;
      wait_to(e);
      n = (5 - (e / D - w / D)) & 7'h7F;
      chk_rd("R2", {1'b0, 7'(n)});
      chk_rn("R2", 1'b1);
    end

    // R7: halt ignored while disarmed
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk_rn("R7", 1'b1);
    @(negedge clk);
    chk_rn("R7", 1'b1);

    // R4: write landing on a tick edge
    while (edges % D != D - 1) @(negedge clk);
    wr(8'h30, w);
    check(w % D == 0, "R4", w % D, 0);
    chk_rd("R4", 8'h30);
    wait_to(w + D - 1);
    chk_rd("R4", 8'h30);
    wait_to(w + D);
    chk_rd("R4", 8'h2F);

    // R3: arm, then write with bit 7 clear keeps it armed
    wr(8'hF0, w);
    chk_rd("R3", 8'hF0);
    wr(8'h7A, w);
    chk_rd("R3", 8'hFA);

    // R5, R8, R9: exhaustive sweep of refresh values C0h..FFh
    for (int t = 0; t < 64; t++) begin
      wr(8'hC0 | 8'(t), w);
      tk = (w / D + t + 1) * D;
      wait_to(tk - 1);
      chk_rd("R5", 8'hC0);
      chk_rn("R5", 1'b1);
      wait_to(tk);
      chk_rd("R5", 8'hBF);
      chk_rn("R5", 1'b1);
      wait_to(tk + 1);
      chk_rn("R5", 1'b0);
      chk_rd("R9", 8'h7F);
      wait_to(tk + P);
      chk_rn("R8", 1'b0);
      wait_to(tk + P + 1);
      chk_rn("R8", 1'b1);
      chk_rd("R9", 8'h7F);
    end

    // R6 + R8: software reset; write and halt during pulse ignored
    wr(8'hA0, w);
    chk_rd("R6", 8'hA0);
    chk_rn("R6", 1'b1);
    wait_to(w + 1);
    chk_rn("R6", 1'b0);
    wait_to(w + 2);
    halt_req = 1'b1;
    wr(8'hC0, h);
    halt_req = 1'b0;
    wait_to(w + P);
    chk_rn("R8", 1'b0);
    wait_to(w + P + 1);
    chk_rn("R8", 1'b1);
    chk_rd("R8", 8'h7F);
    wait_to(w + P + 2);
    chk_rn("R8", 1'b1);

    // R7: halt while armed
    do_reset(1'b0);
    wr(8'hFF, w);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    h = edges;
    chk_rn("R7", 1'b0);
    wait_to(h + P);
    chk_rn("R7", 1'b1);

    // R11: halt in the same cycle as expiry
    wr(8'hC1, w);
    tk = (w / D + 2) * D;
    wait_to(tk);
    chk_rd("R11", 8'hBF);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk_rn("R11", 1'b0);
    wait_to(tk + P);
    chk_rn("R11", 1'b0);
    wait_to(tk + P + 1);
    chk_rn("R11", 1'b1);
    wait_to(tk + P + 2);
    chk_rn("R11", 1'b1);

    // R10: hardware arm
    do_reset(1'b1);
    wr(8'h7E, w);
    chk_rd("R10", 8'hFE);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    h = edges;
    chk_rn("R10", 1'b0);
    chk_rd("R9", 8'hFF);
    wait_to(h + P);
    chk_rn("R10", 1'b1);
    chk_rd("R10", 8'hFF);
    // expiry from 7Fh after 64 ticks
    tk = (h / D + 64) * D;
    wait_to(tk);
    chk_rd("R10", 8'hBF);
    wait_to(tk + 1);
    chk_rn("R10", 1'b0);
    wait_to(tk + P + 1);
    chk_rn("R10", 1'b1);
    chk_rd("R10", 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule